// File: doc/BRIEF.md
# Scanline Interrupt Counter Driven by Video Address Edges

This block counts rendered scanlines without a line clock of its own. It watches the video memory address stream. Each low-to-high change of address bit 12 between two consecutive accesses counts as a scanline pulse. The counter below that pulse raises a level interrupt after a number of lines that software sets.

The video fetch pattern can toggle bit 12 several times in quick succession. A hold-off timer therefore suppresses any rise that comes too soon after the previous one. The timer restarts on every detected rise, whether or not that rise was counted, and it runs down only on system ticks.

Software uses single-cycle write strobes:
- A latch write sets the reload value.
- A reload request empties the counter, so the next counted pulse refills it from the latch.
- An enable write turns interrupts on.
- A disable write turns interrupts off and also clears a pending interrupt. This is how software acknowledges an interrupt.

Top module: `scan_irq_counter`

## Requirements
- R1: A rise is detected on an access (`vid_acc` high) whose `vid_addr` bit 12 is 1 while the previous access had bit 12 at 0. Every access updates the remembered bit, including nametable accesses that have bit 13 set. Repeated accesses with bit 12 high detect nothing.
- R2: Every detected rise loads the hold-off timer with HOLD_CYC (default 6), whether or not the rise is counted.
- R3: A rise is counted only when the hold-off timer reads zero. An uncounted rise leaves the counter and the interrupt unchanged.
- R4: The hold-off timer decrements by one on each cycle with `tick` high while it is nonzero. It holds its value on cycles without `tick`.
- R5: When a counted rise finds the counter at zero, the counter loads the latch value and `irq` takes the current enable state.
- R6: When a counted rise finds the counter nonzero, the counter decrements. If it reaches zero while enabled, `irq` goes high.
- R7: `wr_disable` clears the enable and drops `irq`. `wr_enable` sets the enable and leaves `irq` as it was.
- R8: `wr_reload` clears the counter, so the next counted rise refills it from the latch (`wr_latch` captures `wr_data`).
- R9: Once high, `irq` stays high until `wr_disable` or reset.
- R10: A synchronous active-low reset clears the enable, the hold-off timer, `irq`, the remembered address bit, the counter and the latch.
- R11: In the cycle of a counted rise, `wr_reload` takes priority over the count, and `wr_disable` takes priority over any interrupt the rise would raise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | System tick that paces the hold-off timer |
| vid_acc | input | 1 | A video memory access is presented this cycle |
| vid_addr | input | ADDR_W | Video memory address of the access |
| wr_latch | input | 1 | Write strobe for the reload value |
| wr_reload | input | 1 | Reload request: empty the counter |
| wr_enable | input | 1 | Enable interrupts |
| wr_disable | input | 1 | Disable interrupts and acknowledge a pending one |
| wr_data | input | CNT_W | Data for the latch write |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets hold-off timing:
- A rise that arrives one tick early must not count. A design that counted it would fire one line early.
- Idle cycles without `tick` must not run the timer down. A design that let them would count rises that should be filtered.

Nametable accesses must still update the remembered bit. If they did not, the next pattern-table rise would be missed. The bench also checks the same-cycle clashes of a counted rise with `wr_reload` and with `wr_disable`. Getting either priority wrong shows up as an interrupt one line off, or as an interrupt that survives its own acknowledge. Finally, it checks that reset clears the enable, so a rise right after reset raises nothing.

// File: rtl/scan_irq_pkg.sv
// Package: shared control-strobe type for the scanline interrupt counter.
// Assumes all strobes are single-cycle pulses synchronous to clk.
package scan_irq_pkg;

    typedef struct packed {
        logic latch;    // capture reload value
        logic reload;   // empty the counter
        logic enable;   // set interrupt enable
        logic disable_; // clear enable and acknowledge
    } scan_ctl_t;

endpackage

// File: rtl/scan_edge_detect.sv
// Module: remembers the watched address bit of the last access and flags a
// low-to-high change on the current access. Assumes vid_acc qualifies the address.
module scan_edge_detect #(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned EDGE_BIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              rise_o
);

    logic last_bit_q;
    logic unused_addr_bits;

    // Sink for the address bits that carry no edge information.
    assign unused_addr_bits = ^{acc_addr[ADDR_W-1:EDGE_BIT+1], acc_addr[EDGE_BIT-1:0]};

    // Rise: previous access had the bit low, this one has it high.
    assign rise_o = acc_valid && !last_bit_q && acc_addr[EDGE_BIT];

    // Track the watched bit on every access, nametable fetches included.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_bit_q <= 1'b0;
        end else if (acc_valid) begin
            last_bit_q <= acc_addr[EDGE_BIT];
        end
    end

endmodule

// File: rtl/scan_holdoff.sv
// Module: hold-off timer. Every rise restarts it; ticks run it down to zero.
// A rise counts only while the timer is at zero. Assumes tick is one cycle wide.
module scan_holdoff #(
    parameter int unsigned HOLD_CYC = 6,
    localparam int unsigned HOLD_W  = $clog2(HOLD_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rise,
    output logic              count_edge_o,
    output logic [HOLD_W-1:0] hold_o
);

    logic [HOLD_W-1:0] hold_q;

    assign hold_o       = hold_q;
    // A rise passes the filter only when the window has fully expired.
    assign count_edge_o = rise && (hold_q == '0);

    // Restart on a rise, otherwise count down once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (rise) begin
            hold_q <= HOLD_W'(HOLD_CYC);
        end else if (tick && hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
        end
    end

endmodule

// File: rtl/scan_count_irq.sv
// Module: reload latch, scanline down-counter, enable and level interrupt.
// Assumes count_edge is already filtered. A reload write beats a counted
// edge, and a disable write beats an interrupt raised in the same cycle.
module scan_count_irq
    import scan_irq_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_edge,
    input  scan_ctl_t        ctl,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq_o,
    output logic             en_o,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] count_q;
    logic             en_q;
    logic             irq_q;
    logic             step;
    logic             at_zero;
    logic             at_one;

    assign step    = count_edge && !ctl.reload;
    assign at_zero = (count_q == '0);
    assign at_one  = (count_q == CNT_W'(1));
    assign irq_o   = irq_q;
    assign en_o    = en_q;
    assign count_o = count_q;

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)          latch_q <= '0;
        else if (ctl.latch)  latch_q <= wr_data;
    end

    // Scanline counter: cleared by a request, otherwise refill or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= '0;
        else if (ctl.reload) count_q <= '0;
        else if (step)       count_q <= at_zero ? latch_q : count_q - 1'b1;
    end

    // Interrupt enable: disable has priority over enable.
    always_ff @(posedge clk) begin
        if (!rst_n)            en_q <= 1'b0;
        else if (ctl.disable_) en_q <= 1'b0;
        else if (ctl.enable)   en_q <= 1'b1;
    end

    // Level interrupt: set by counting, dropped only by disable or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (ctl.disable_) begin
            irq_q <= 1'b0;
        end else if (step) begin
            if (at_zero)            irq_q <= en_q;
            else if (at_one && en_q) irq_q <= 1'b1;
        end
    end

endmodule

// File: rtl/scan_irq_counter.sv
// Module: top of the scanline interrupt counter. Joins edge detection,
// hold-off filtering and the counter/interrupt stage. Assumes all write
// strobes and tick are single-cycle pulses synchronous to clk.
module scan_irq_counter
    import scan_irq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned EDGE_BIT = 12,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned HOLD_CYC = 6,
    localparam int unsigned HOLD_W  = $clog2(HOLD_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              vid_acc,
    input  logic [ADDR_W-1:0] vid_addr,
    input  logic              wr_latch,
    input  logic              wr_reload,
    input  logic              wr_enable,
    input  logic              wr_disable,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              irq
);

    logic              edge_rise;
    logic              count_edge;
    logic [HOLD_W-1:0] hold_cnt;
    logic [CNT_W-1:0]  count_q;
    logic              en_q;
    scan_ctl_t         ctl;

    // Collect the write strobes into one control bundle.
    assign ctl = '{latch: wr_latch, reload: wr_reload,
                   enable: wr_enable, disable_: wr_disable};

    scan_edge_detect #(.ADDR_W(ADDR_W), .EDGE_BIT(EDGE_BIT)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (vid_acc),
        .acc_addr  (vid_addr),
        .rise_o    (edge_rise)
    );

    scan_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .rise         (edge_rise),
        .count_edge_o (count_edge),
        .hold_o       (hold_cnt)
    );

    scan_count_irq #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_edge (count_edge),
        .ctl        (ctl),
        .wr_data    (wr_data),
        .irq_o      (irq),
        .en_o       (en_q),
        .count_o    (count_q)
    );

endmodule

// File: rtl/scan_irq_counter_chk.sv
// Checker: temporal properties of the scanline interrupt counter, bound to the top.
module scan_irq_counter_chk #(
    parameter int unsigned HOLD_CYC = 6,
    parameter int unsigned HOLD_W   = 3,
    parameter int unsigned CNT_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_reload,
    input logic              wr_disable,
    input logic              irq,
    input logic              edge_rise,
    input logic [HOLD_W-1:0] hold_cnt,
    input logic [CNT_W-1:0]  count_q,
    input logic              en_q
);

    // R2: any detected rise restarts the hold-off window
    a_r2_hold_restart: assert property (@(posedge clk) disable iff (!rst_n)
        edge_rise |=> hold_cnt == HOLD_W'(HOLD_CYC));

    // R4: ticks run the timer down one step at a time
    a_r4_hold_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_rise && tick && hold_cnt != '0) |=> hold_cnt == HOLD_W'($past(hold_cnt) - 1'b1));

    // R4: without a tick or a rise the timer holds
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_rise && !tick) |=> $stable(hold_cnt));

    // R3: a rise inside the window leaves the counter untouched
    a_r3_filtered_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_rise && hold_cnt != '0 && !wr_reload) |=> $stable(count_q));

    // R6: a new interrupt needs a counted rise while enabled
    a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(edge_rise && hold_cnt == '0 && en_q));

    // R7: disable drops the line and the enable
    a_r7_disable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_disable |=> (!irq && !en_q));

    // R8: reload request empties the counter
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload |=> count_q == '0);

    // R9: line is sticky until acknowledged
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_disable) |=> irq);

endmodule

bind scan_irq_counter scan_irq_counter_chk #(
    .HOLD_CYC(HOLD_CYC), .HOLD_W(HOLD_W), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_reload  (wr_reload),
    .wr_disable (wr_disable),
    .irq        (irq),
    .edge_rise  (edge_rise),
    .hold_cnt   (hold_cnt),
    .count_q    (count_q),
    .en_q       (en_q)
);

// File: tb/scan_irq_counter_test.sv
`timescale 1ns/1ps
// Bench: walks a vector table of operations, checking irq after each flagged step.
module scan_irq_counter_test;

    localparam int ADDR_W = 14;
    localparam int CNT_W  = 8;

    // Operation codes for the vector table.
    localparam logic [3:0] OP_NOP = 4'd0, OP_ACC = 4'd1, OP_TICK = 4'd2, OP_IDLE = 4'd3,
                           OP_LAT = 4'd4, OP_RLD = 4'd5, OP_EN = 4'd6, OP_DIS = 4'd7,
                           OP_RST = 4'd8, OP_SCAN = 4'd9, OP_SCANRLD = 4'd10,
                           OP_SCANDIS = 4'd11;
    // Vector: {op, data, requirement number (0 = no check), expected irq}.
    // ACC uses address = data << 6 (0x40 -> bit 12, 0x80 -> bit 13).
    // SCAN variants: data ticks, access 0x0000, then access 0x1000.
    localparam int NV = 54;
    localparam logic [16:0] VEC [NV] = '{
        {OP_NOP,  8'h00, 4'd10, 1'b0},  // R10 idle after reset
        {OP_EN,   8'h00, 4'd7,  1'b0},  // R7 enable does not raise
        {OP_ACC,  8'h40, 4'd10, 1'b1},  // R10 remembered bit cleared: rise
        {OP_DIS,  8'h00, 4'd7,  1'b0},  // R7
        {OP_TICK, 8'd6,  4'd0,  1'b0},
        {OP_EN,   8'h00, 4'd0,  1'b0},
        {OP_ACC,  8'h40, 4'd1,  1'b0},  // R1 high again: no rise
        {OP_ACC,  8'hC0, 4'd1,  1'b0},  // R1 nametable high: no rise
        {OP_ACC,  8'h80, 4'd0,  1'b0},  // nametable low updates memory
        {OP_ACC,  8'h40, 4'd1,  1'b1},  // R1 rise after nametable low
        {OP_DIS,  8'h00, 4'd7,  1'b0},
        {OP_LAT,  8'd2,  4'd0,  1'b0},
        {OP_RLD,  8'h00, 4'd0,  1'b0},
        {OP_SCAN, 8'd6,  4'd5,  1'b0},  // R5 refill, irq = enable(0)
        {OP_EN,   8'h00, 4'd0,  1'b0},
        {OP_SCAN, 8'd6,  4'd6,  1'b0},  // R6 2->1
        {OP_SCAN, 8'd6,  4'd6,  1'b1},  // R6 1->0 fires
        {OP_TICK, 8'd20, 4'd9,  1'b1},  // R9 sticky
        {OP_SCAN, 8'd0,  4'd9,  1'b1},  // R9 refill keeps line
        {OP_DIS,  8'h00, 4'd9,  1'b0},
        {OP_EN,   8'h00, 4'd7,  1'b0},
        {OP_SCAN, 8'd6,  4'd6,  1'b0},  // 2->1
        {OP_SCAN, 8'd5,  4'd3,  1'b0},  // R3 timer at 1: filtered
        {OP_IDLE, 8'd10, 4'd0,  1'b0},
        {OP_SCAN, 8'd0,  4'd4,  1'b0},  // R4 idle did not run timer
        {OP_SCAN, 8'd6,  4'd3,  1'b1},  // R3 counted 1->0
        {OP_DIS,  8'h00, 4'd7,  1'b0},
        {OP_LAT,  8'd3,  4'd0,  1'b0},
        {OP_SCAN, 8'd6,  4'd0,  1'b0},  // 0->3
        {OP_SCAN, 8'd6,  4'd8,  1'b0},  // R8 3->2
        {OP_RLD,  8'h00, 4'd0,  1'b0},
        {OP_EN,   8'h00, 4'd0,  1'b0},
        {OP_SCAN, 8'd6,  4'd8,  1'b1},  // R8 emptied: refill fires
        {OP_DIS,  8'h00, 4'd0,  1'b0},
        {OP_EN,   8'h00, 4'd0,  1'b0},
        {OP_SCAN, 8'd6,  4'd8,  1'b0},  // R8 3->2
        {OP_SCAN, 8'd6,  4'd8,  1'b0},  // R8 2->1
        {OP_SCAN, 8'd6,  4'd8,  1'b1},  // R8 latch value 3 honoured
        {OP_DIS,  8'h00, 4'd0,  1'b0},
        {OP_EN,   8'h00, 4'd0,  1'b0},
        {OP_SCAN, 8'd6,  4'd5,  1'b1},  // R5 refill with enable set
        {OP_DIS,  8'h00, 4'd0,  1'b0},
        {OP_EN,   8'h00, 4'd0,  1'b0},
        {OP_SCANRLD, 8'd6, 4'd11, 1'b0}, // R11 reload beats count
        {OP_SCAN, 8'd6,  4'd11, 1'b1},  // R11 counter was emptied
        {OP_DIS,  8'h00, 4'd0,  1'b0},
        {OP_EN,   8'h00, 4'd0,  1'b0},
        {OP_SCAN, 8'd6,  4'd0,  1'b0},  // 3->2
        {OP_SCAN, 8'd6,  4'd0,  1'b0},  // 2->1
        {OP_SCANDIS, 8'd6, 4'd11, 1'b0}, // R11 disable beats fire
        {OP_EN,   8'h00, 4'd0,  1'b0},
        {OP_SCAN, 8'd6,  4'd5,  1'b1},  // R5
        {OP_RST,  8'h00, 4'd10, 1'b0},  // R10 reset drops line
        {OP_ACC,  8'h40, 4'd10, 1'b0}   // R10 enable cleared by reset
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              vid_acc = 1'b0;
    logic [ADDR_W-1:0] vid_addr = '0;
    logic              wr_latch = 1'b0, wr_reload = 1'b0, wr_enable = 1'b0, wr_disable = 1'b0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic              irq;
    int                checks = 0;
    int                failures = 0;
    int                cycles = 0;

    always #4 clk = ~clk;

    scan_irq_counter uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .vid_acc(vid_acc), .vid_addr(vid_addr),
        .wr_latch(wr_latch), .wr_reload(wr_reload), .wr_enable(wr_enable),
        .wr_disable(wr_disable), .wr_data(wr_data), .irq(irq)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input int req, input logic exp);
        checks = checks + 1;
        if (irq !== exp) begin
            failures = failures + 1;
            $display("FAIL R%0d irq actual=%b expected=%b", req, irq, exp);
        end
    endtask

    // One access cycle; optional same-cycle reload or disable strobe.
    task automatic access(input logic [7:0] d, input logic rld, input logic dis);
        vid_acc = 1'b1; vid_addr = ADDR_W'({d, 6'b0});
        wr_reload = rld; wr_disable = dis;
        @(negedge clk);
        vid_acc = 1'b0; wr_reload = 1'b0; wr_disable = 1'b0;
    endtask

    task automatic ticks(input int n, input logic t);
        tick = t;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic strobe(input logic [3:0] op, input logic [7:0] d);
        wr_data = d;
        wr_latch = (op == OP_LAT); wr_reload = (op == OP_RLD);
        wr_enable = (op == OP_EN); wr_disable = (op == OP_DIS);
        rst_n = (op != OP_RST);
        @(negedge clk);
        wr_latch = 1'b0; wr_reload = 1'b0; wr_enable = 1'b0; wr_disable = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [3:0] op;
            logic [7:0] d;
            op = VEC[i][16:13];
            d  = VEC[i][12:5];
            case (op)
                OP_ACC:     access(d, 1'b0, 1'b0);
                OP_TICK:    ticks(int'(d), 1'b1);
                OP_IDLE:    ticks(int'(d), 1'b0);
                OP_SCAN:    begin ticks(int'(d), 1'b1); access(8'h00, 1'b0, 1'b0); access(8'h40, 1'b0, 1'b0); end
                OP_SCANRLD: begin ticks(int'(d), 1'b1); access(8'h00, 1'b0, 1'b0); access(8'h40, 1'b1, 1'b0); end
                OP_SCANDIS: begin ticks(int'(d), 1'b1); access(8'h00, 1'b0, 1'b0); access(8'h40, 1'b0, 1'b1); end
                default:    strobe(op, d);
            endcase
            if (VEC[i][4:1] != 4'd0) check(int'(VEC[i][4:1]), VEC[i][0]);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule